// File: doc/BRIEF.md
# Multiplexed Micro-Packet Stream Reassembler

This block accepts a stream of 32-bit words from an interleaved capture source. Each word carries one header byte and three payload bytes. The header selects one of four source channels and holds a position tag, a start marker and an error marker. The block sorts each word into a per-channel assembly buffer. When a buffer holds a full 188-byte transport packet, the block sends that packet out as a byte stream, tagged with its logical channel number.

Software can enable or disable each channel. The block keeps per-channel counters of finished packets, dropped words, abandoned partial packets and error words. A word whose channel field is invalid produces a one-cycle channel error pulse. A word with the error marker set produces a one-cycle error pulse and throws away all partial packets. While a packet is being sent, the input port is held off, so a finished packet is never lost.

Top module: `mpr_reassembler`

## Requirements
- R1: `inWord[31:24]` is the header. Payload bytes are appended to a channel buffer in the order `inWord[23:16]`, `inWord[15:8]`, `inWord[7:0]`.
- R2: The source field is header bits 7:5. Source values 1, 2, 3 and 4 map to logical channels 0, 2, 1 and 3, and the logical channel is what `outChan` carries.
- R3: A packet is complete when its channel buffer reaches 188 bytes. Any payload bytes of the completing word beyond byte 188 are discarded, and the channel fill returns to zero. The packet is then sent as 188 bytes: `outSop` is high on the first byte, `outEop` is high on the last byte, and `outTag` carries header bits 4:2 of the completing word. That channel's `pktCount` field (bits `[16c+15:16c]` for channel c) increments.
- R4: If header bit 1 (start) is set while the channel holds a partial packet, the partial data is discarded, assembly restarts with this word, and `restartCount` for that channel increments. A start on an empty channel leaves `restartCount` unchanged.
- R5: A word for a channel whose `chanEn` bit is low is dropped. It produces no output, it does not touch that channel's partial packet, and `dropCount` for that channel increments.
- R6: A word whose source field is 0, 5, 6 or 7 (with header bit 0 clear) is skipped. `chanErr` pulses for one cycle, in the cycle after the word is accepted, and no counter or buffer changes.
- R7: A word with header bit 0 (error) set stores nothing. `errEvent` pulses for one cycle after acceptance and all partial packets are discarded. If the source field is valid, `errCount` for the decoded channel increments.
- R8: While a packet is being sent, `inReady` is low. While `outReady` is low, `outByte`, `outChan` and the markers hold steady, and no byte is skipped.
- R9: After reset, `inReady` is high, `outValid` is low, and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input word valid |
| inReady | output | 1 | Block can accept a word |
| inWord | input | 32 | Header byte and three payload bytes |
| chanEn | input | 4 | Per-logical-channel enable |
| outValid | output | 1 | Output byte valid |
| outReady | input | 1 | Downstream accepts the byte |
| outByte | output | 8 | Packet byte |
| outChan | output | 2 | Logical channel of the packet |
| outTag | output | 3 | Position tag of the completing word |
| outSop | output | 1 | First byte of a packet |
| outEop | output | 1 | Last byte of a packet |
| chanErr | output | 1 | Pulse: invalid source field |
| errEvent | output | 1 | Pulse: error-marked word |
| pktCount | output | 64 | Completed packets, 16 bits per channel |
| dropCount | output | 64 | Words dropped on disabled channels |
| restartCount | output | 64 | Partial packets abandoned by a start |
| errCount | output | 64 | Error-marked words per channel |

## Verification
Single-channel packets are sent from each source value, which separates the channel remap from the byte order and the leftover-byte discard. Word-by-word interleaving of all four channels shows that the buffers stay independent. Start markers on partial and empty channels separate a restart from an ordinary start. Disabled-channel, invalid-source and error-marked words are placed inside live partial packets, so that any unwanted effect on a buffer shows up in the next packet. A phase with a stalling output then shows whether bytes are held or lost under backpressure.

// File: rtl/mpr_pkg.sv
package mpr_pkg;
  localparam int NUM_CH = 4;
  localparam int CH_W = 2;
  localparam int BYTES_PER_WORD = 3;

  typedef enum logic {COLLECT, EMIT} phase_t;

  // strobes from control to datapath, all for the channel on selChan
  typedef struct packed {
    logic wrEn;        // store payload of accepted word
    logic restart;     // start flag: fill starts from zero
    logic clearAll;    // error word: drop every partial packet
    logic emitStart;   // this word completes a packet
    logic emitStep;    // one output byte leaves
    logic incDrop;
    logic incErr;
    logic incRestart;
  } ctrlStrobes_t;
endpackage

// File: rtl/mpr_ctrl.sv
module mpr_ctrl
  import mpr_pkg::*;
#(
  parameter int PKT_LEN = 188,
  parameter int FILL_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [2:0]        srcField,
  input  logic              sopFlag,
  input  logic              errFlag,
  input  logic [NUM_CH-1:0] chanEn,
  input  logic              outReady,
  input  logic [FILL_W-1:0] selFill,
  input  logic              emitLast,
  output logic              inReady,
  output logic              outValid,
  output logic [CH_W-1:0]   selChan,
  output ctrlStrobes_t      st,
  output logic              chanErr,
  output logic              errEvent
);
  phase_t phase;
  logic accept, srcOk, doStore;
  logic [1:0] srcIdx;
  logic [FILL_W-1:0] baseFill, newFill;

  assign inReady  = (phase == COLLECT);
  assign outValid = (phase == EMIT);
  assign accept   = inValid && inReady;

  // source values are 1-based; remap 1,2,3,4 -> 0,2,1,3 (swap of index bits)
  assign srcOk   = (srcField != 3'd0) && (int'(srcField) <= NUM_CH);
  assign srcIdx  = srcField[1:0] - 2'd1;
  assign selChan = {srcIdx[0], srcIdx[1]};

  assign baseFill = sopFlag ? '0 : selFill;
  assign newFill  = baseFill + FILL_W'(BYTES_PER_WORD);
  assign doStore  = accept && !errFlag && srcOk && chanEn[selChan];

  always_comb begin
    st            = '0;
    st.wrEn       = doStore;
    st.restart    = sopFlag;
    st.incRestart = doStore && sopFlag && (selFill != '0);
    st.emitStart  = doStore && (newFill >= FILL_W'(PKT_LEN));
    st.incDrop    = accept && !errFlag && srcOk && !chanEn[selChan];
    st.incErr     = accept && errFlag && srcOk;
    st.clearAll   = accept && errFlag;
    st.emitStep   = outValid && outReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= COLLECT;
      chanErr  <= 1'b0;
      errEvent <= 1'b0;
    end else begin
      chanErr  <= accept && !errFlag && !srcOk;
      errEvent <= accept && errFlag;
      if (st.emitStart)
        phase <= EMIT;
      else if (st.emitStep && emitLast)
        phase <= COLLECT;
    end
  end
endmodule

// File: rtl/mpr_datapath.sv
module mpr_datapath
  import mpr_pkg::*;
#(
  parameter int PKT_LEN = 188,
  parameter int FILL_W = 8,
  parameter int CNT_W = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobes_t            st,
  input  logic [CH_W-1:0]         selChan,
  input  logic [8*BYTES_PER_WORD-1:0] payload,
  input  logic [2:0]              tagIn,
  output logic [FILL_W-1:0]       selFill,
  output logic [7:0]              outByte,
  output logic [CH_W-1:0]         outChan,
  output logic [2:0]              outTag,
  output logic                    firstByte,
  output logic                    emitLast,
  output logic [NUM_CH*CNT_W-1:0] pktCount,
  output logic [NUM_CH*CNT_W-1:0] dropCount,
  output logic [NUM_CH*CNT_W-1:0] restartCount,
  output logic [NUM_CH*CNT_W-1:0] errCount
);
  logic [FILL_W-1:0] fill [NUM_CH];
  logic [7:0] pktBuf [NUM_CH][PKT_LEN];
  logic [FILL_W-1:0] wrBase;
  logic [FILL_W-1:0] wrPos [BYTES_PER_WORD];
  logic [FILL_W-1:0] emitIdx;

  assign selFill = fill[selChan];
  assign wrBase  = st.restart ? '0 : selFill;

  always_comb
    for (int k = 0; k < BYTES_PER_WORD; k++)
      wrPos[k] = wrBase + FILL_W'(k);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CH; c++) fill[c] <= '0;
    end else if (st.clearAll) begin
      for (int c = 0; c < NUM_CH; c++) fill[c] <= '0;
    end else if (st.wrEn) begin
      fill[selChan] <= st.emitStart ? '0 : wrBase + FILL_W'(BYTES_PER_WORD);
    end
  end

  // first payload byte sits in the top lane; lanes past the packet end are discarded
  always_ff @(posedge clk) begin
    if (st.wrEn)
      for (int k = 0; k < BYTES_PER_WORD; k++)
        if (wrPos[k] < FILL_W'(PKT_LEN))
          pktBuf[selChan][wrPos[k]] <= payload[8*(BYTES_PER_WORD-1-k) +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      emitIdx <= '0;
      outChan <= '0;
      outTag  <= '0;
    end else if (st.emitStart) begin
      emitIdx <= '0;
      outChan <= selChan;
      outTag  <= tagIn;
    end else if (st.emitStep) begin
      emitIdx <= emitIdx + 1'b1;
    end
  end

  assign outByte   = pktBuf[outChan][emitIdx];
  assign firstByte = (emitIdx == '0);
  assign emitLast  = (emitIdx == FILL_W'(PKT_LEN - 1));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_stat
    logic hit;
    logic [CNT_W-1:0] pktC, dropC, rstC, errC;
    assign hit = (selChan == CH_W'(c));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        pktC <= '0; dropC <= '0; rstC <= '0; errC <= '0;
      end else begin
        if (hit && st.emitStart)  pktC  <= pktC + 1'b1;
        if (hit && st.incDrop)    dropC <= dropC + 1'b1;
        if (hit && st.incRestart) rstC  <= rstC + 1'b1;
        if (hit && st.incErr)     errC  <= errC + 1'b1;
      end
    end
    assign pktCount[c*CNT_W +: CNT_W]     = pktC;
    assign dropCount[c*CNT_W +: CNT_W]    = dropC;
    assign restartCount[c*CNT_W +: CNT_W] = rstC;
    assign errCount[c*CNT_W +: CNT_W]     = errC;
  end
endmodule

// File: rtl/mpr_reassembler.sv
module mpr_reassembler
  import mpr_pkg::*;
#(
  parameter int PKT_LEN = 188,
  parameter int CNT_W = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  output logic                    inReady,
  input  logic [31:0]             inWord,
  input  logic [NUM_CH-1:0]       chanEn,
  output logic                    outValid,
  input  logic                    outReady,
  output logic [7:0]              outByte,
  output logic [CH_W-1:0]         outChan,
  output logic [2:0]              outTag,
  output logic                    outSop,
  output logic                    outEop,
  output logic                    chanErr,
  output logic                    errEvent,
  output logic [NUM_CH*CNT_W-1:0] pktCount,
  output logic [NUM_CH*CNT_W-1:0] dropCount,
  output logic [NUM_CH*CNT_W-1:0] restartCount,
  output logic [NUM_CH*CNT_W-1:0] errCount
);
  localparam int FILL_W = $clog2(PKT_LEN + BYTES_PER_WORD);

  ctrlStrobes_t st;
  logic [CH_W-1:0] selChan;
  logic [FILL_W-1:0] selFill;
  logic firstByte, emitLast;

  mpr_ctrl #(.PKT_LEN(PKT_LEN), .FILL_W(FILL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .srcField(inWord[31:29]), .sopFlag(inWord[25]), .errFlag(inWord[24]),
    .chanEn(chanEn), .outReady(outReady), .selFill(selFill), .emitLast(emitLast),
    .inReady(inReady), .outValid(outValid), .selChan(selChan), .st(st),
    .chanErr(chanErr), .errEvent(errEvent)
  );

  mpr_datapath #(.PKT_LEN(PKT_LEN), .FILL_W(FILL_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .selChan(selChan),
    .payload(inWord[23:0]), .tagIn(inWord[28:26]),
    .selFill(selFill), .outByte(outByte), .outChan(outChan), .outTag(outTag),
    .firstByte(firstByte), .emitLast(emitLast),
    .pktCount(pktCount), .dropCount(dropCount),
    .restartCount(restartCount), .errCount(errCount)
  );

  assign outSop = outValid && firstByte;
  assign outEop = outValid && emitLast;
endmodule

// File: rtl/mpr_reassembler_chk.sv
module mpr_reassembler_chk #(
  parameter int CNT_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               inReady,
  input logic               outValid,
  input logic               outReady,
  input logic [7:0]         outByte,
  input logic [1:0]         outChan,
  input logic               outSop,
  input logic               outEop,
  input logic               chanErr,
  input logic               errEvent,
  input logic [4*CNT_W-1:0] pktCount,
  input logic [4*CNT_W-1:0] dropCount
);
  // R8
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outByte) && $stable(outChan) && $stable(outSop));

  // R8
  input_blocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady);

  // R3
  done_starts_emit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pktCount) |-> outValid && outSop);

  // R3
  eop_closes_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outReady && outEop |=> !outValid);

  // R3
  packet_continues_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outReady && !outEop |=> outValid && !outSop);

  // R6
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({chanErr, errEvent}));

  // R6
  bad_src_inert_chk: assert property (@(posedge clk) disable iff (!rstN)
    chanErr |-> $stable(pktCount) && $stable(dropCount));
endmodule

bind mpr_reassembler mpr_reassembler_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .inReady(inReady), .outValid(outValid), .outReady(outReady),
  .outByte(outByte), .outChan(outChan), .outSop(outSop), .outEop(outEop),
  .chanErr(chanErr), .errEvent(errEvent), .pktCount(pktCount), .dropCount(dropCount)
);

// File: tb/mpr_reassembler_bench.sv
`timescale 1ns/1ps
module mpr_reassembler_bench;
  localparam int PLEN = 188;
  localparam int CW = 16;
  localparam int NC = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic inReady;
  logic [31:0] inWord = '0;
  logic [NC-1:0] chanEn = '1;
  logic outValid;
  logic outReady = 1'b1;
  logic [7:0] outByte;
  logic [1:0] outChan;
  logic [2:0] outTag;
  logic outSop, outEop, chanErr, errEvent;
  logic [NC*CW-1:0] pktCount, dropCount, restartCount, errCount;

  always #4 clk = ~clk;

  mpr_reassembler u_mpr_reassembler (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inWord(inWord),
    .chanEn(chanEn), .outValid(outValid), .outReady(outReady), .outByte(outByte),
    .outChan(outChan), .outTag(outTag), .outSop(outSop), .outEop(outEop),
    .chanErr(chanErr), .errEvent(errEvent), .pktCount(pktCount), .dropCount(dropCount),
    .restartCount(restartCount), .errCount(errCount)
  );

  int checks = 0;
  int fails = 0;

  // bench model
  int mFill [NC];
  logic [7:0] mBuf [NC][PLEN];
  int mPkt [NC], mDrop [NC], mRst [NC], mErr [NC];
  logic [7:0] expByteQ [$];
  int expChanQ [$];
  int expTagQ [$];
  logic [7:0] seq = 8'd1;
  int wordNo = 0;
  bit stallMode = 1'b0;
  int stallCyc = 0;

  task automatic chkEq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int logicalOf(input int src);
    case (src)
      1: return 0;
      2: return 2;
      3: return 1;
      default: return 3;
    endcase
  endfunction

  task automatic modelWord(input logic [7:0] hdr, input logic [23:0] pay);
    int src, lch, base;
    src = int'(hdr[7:5]);
    if (hdr[0]) begin
      if (src >= 1 && src <= 4) mErr[logicalOf(src)]++;
      for (int c = 0; c < NC; c++) mFill[c] = 0;
      return;
    end
    if (src < 1 || src > 4) return;
    lch = logicalOf(src);
    if (!chanEn[lch]) begin
      mDrop[lch]++;
      return;
    end
    base = mFill[lch];
    if (hdr[1]) begin
      if (base != 0) mRst[lch]++;
      base = 0;
    end
    for (int k = 0; k < 3; k++) begin
      if (base < PLEN) mBuf[lch][base] = pay[23-8*k -: 8];
      base++;
    end
    if (base >= PLEN) begin
      for (int i = 0; i < PLEN; i++) expByteQ.push_back(mBuf[lch][i]);
      expChanQ.push_back(lch);
      expTagQ.push_back(int'(hdr[4:2]));
      mPkt[lch]++;
      mFill[lch] = 0;
    end else begin
      mFill[lch] = base;
    end
  endtask

  task automatic sendWord(input int src, input bit sop, input bit err);
    logic [7:0] hdr;
    logic [23:0] pay;
    hdr = {3'(src), 3'(wordNo), sop, err};
    pay = {seq, seq + 8'd1, seq + 8'd2};
    seq = seq + 8'd3;
    wordNo++;
    @(negedge clk);
    inWord = {hdr, pay};
    inValid = 1'b1;
    while (!inReady) @(negedge clk);
    @(negedge clk);
    inValid = 1'b0;
    modelWord(hdr, pay);
  endtask

  task automatic sendRun(input int src, input int n, input bit firstSop);
    for (int i = 0; i < n; i++) sendWord(src, firstSop && (i == 0), 1'b0);
  endtask

  task automatic drain();
    int n = 0;
    while ((expByteQ.size() != 0 || outValid) && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chkEq("R3", "expected bytes left after drain", expByteQ.size(), 0);
  endtask

  task automatic checkCounters(input string phase);
    for (int c = 0; c < NC; c++) begin
      chkEq("R3", {phase, " pktCount"}, int'(pktCount[c*CW +: CW]), mPkt[c]);
      chkEq("R5", {phase, " dropCount"}, int'(dropCount[c*CW +: CW]), mDrop[c]);
      chkEq("R4", {phase, " restartCount"}, int'(restartCount[c*CW +: CW]), mRst[c]);
      chkEq("R7", {phase, " errCount"}, int'(errCount[c*CW +: CW]), mErr[c]);
    end
  endtask

  // output pacing, changed just after the rising edge
  always @(posedge clk) begin
    #1;
    stallCyc++;
    outReady = stallMode ? ((stallCyc % 3) != 1) && ((stallCyc % 7) != 3) : 1'b1;
  end

  // output monitor
  int byteIdx = 0;
  bit pktBad = 1'b0;
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (inReady) begin
        checks++; fails++;
        $display("FAIL R8 inReady high during emission: actual 1 expected 0");
      end
      if (outReady) begin
        if (byteIdx == 0) begin
          pktBad = 1'b0;
          if (expChanQ.size() == 0) begin
            pktBad = 1'b1;
            $display("FAIL R3 unexpected packet: actual chan %0d expected none", outChan);
          end else begin
            int ec, et;
            ec = expChanQ.pop_front();
            et = expTagQ.pop_front();
            if (int'(outChan) != ec || int'(outTag) != et) begin
              pktBad = 1'b1;
              $display("FAIL R2 chan/tag: actual %0d/%0d expected %0d/%0d", outChan, outTag, ec, et);
            end
          end
          if (!outSop && !pktBad) begin
            pktBad = 1'b1;
            $display("FAIL R3 outSop on first byte: actual 0 expected 1");
          end
        end
        if (expByteQ.size() != 0) begin
          logic [7:0] eb;
          eb = expByteQ.pop_front();
          if (outByte != eb && !pktBad) begin
            pktBad = 1'b1;
            $display("FAIL R1 byte %0d: actual %0d expected %0d", byteIdx, outByte, eb);
          end
        end
        if (outEop != (byteIdx == PLEN - 1) && !pktBad) begin
          pktBad = 1'b1;
          $display("FAIL R3 outEop at byte %0d: actual %0d expected %0d", byteIdx, outEop, byteIdx == PLEN - 1);
        end
        byteIdx++;
        if (byteIdx == PLEN || outEop) begin
          checks++;
          if (pktBad) fails++;
          byteIdx = 0;
        end
      end
    end
  end

  initial begin
    for (int c = 0; c < NC; c++) begin
      mFill[c] = 0; mPkt[c] = 0; mDrop[c] = 0; mRst[c] = 0; mErr[c] = 0;
    end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R9 reset state
    chkEq("R9", "inReady after reset", int'(inReady), 1);
    chkEq("R9", "outValid after reset", int'(outValid), 0);
    checkCounters("R9 reset");

    // R1 R2 R3: one packet per source value
    for (int s = 1; s <= 4; s++) begin
      sendRun(s, 63, 1'b1);
      drain();
    end
    checkCounters("single");

    // R2 R3: word-by-word interleaving of all channels
    for (int w = 0; w < 3 * 63; w++)
      for (int s = 1; s <= 4; s++) sendWord(s, 1'b0, 1'b0);
    drain();
    checkCounters("interleave");
    chkEq("R6", "chanErr quiet on valid words", int'(chanErr), 0);

    // R4: start on a partial channel, then start on an empty channel
    sendRun(2, 10, 1'b0);
    sendRun(2, 63, 1'b1);
    sendRun(4, 63, 1'b1);
    drain();
    checkCounters("restart");

    // R5: disabled words, including a start, leave the partial untouched
    sendRun(1, 20, 1'b0);
    @(negedge clk); chanEn[0] = 1'b0;
    sendWord(1, 1'b1, 1'b0);
    sendRun(1, 4, 1'b0);
    chkEq("R5", "no output for disabled words", int'(outValid), 0);
    @(negedge clk); chanEn[0] = 1'b1;
    sendRun(1, 43, 1'b0);
    drain();
    checkCounters("disabled");

    // R6: invalid source values inside a partial packet
    sendRun(4, 30, 1'b0);
    for (int s = 0; s < 8; s++) begin
      if (s >= 1 && s <= 4) continue;
      sendWord(s, 1'b0, 1'b0);
      chkEq("R6", "chanErr pulse", int'(chanErr), 1);
      chkEq("R6", "no errEvent on bad source", int'(errEvent), 0);
      @(negedge clk);
      chkEq("R6", "chanErr one cycle", int'(chanErr), 0);
    end
    checkCounters("badsrc");
    sendRun(4, 33, 1'b0);
    drain();
    checkCounters("badsrc end");

    // R7: error words clear every partial packet
    sendRun(1, 10, 1'b0);
    sendRun(3, 10, 1'b0);
    sendWord(1, 1'b0, 1'b1);
    chkEq("R7", "errEvent pulse", int'(errEvent), 1);
    chkEq("R7", "no chanErr on error word", int'(chanErr), 0);
    sendWord(0, 1'b0, 1'b1);
    chkEq("R7", "errEvent on error word with bad source", int'(errEvent), 1);
    checkCounters("error");
    sendRun(1, 63, 1'b0);
    sendRun(3, 63, 1'b0);
    drain();
    checkCounters("error end");

    // R8: output stalls
    stallMode = 1'b1;
    for (int w = 0; w < 2 * 63; w++) begin
      sendWord(2, 1'b0, 1'b0);
      sendWord(4, 1'b0, 1'b0);
    end
    drain();
    stallMode = 1'b0;
    checkCounters("R8 stall");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule